// File: doc/BRIEF.md
# Authentication Control and Interrupt Register Block

This block is the software-facing control and status register set for a link-encryption authentication engine. A host reaches it through a simple byte-wide read/write bus. The external engine reports its outcome through single-cycle event pulses for success, failure and loss of authentication. In return the block issues a one-cycle start/restart request to the engine. It holds the enabled, authenticated, encryption-status and mute state, and keeps per-event interrupt flags behind a mask. An active-low interrupt line goes to the host.

Software starts or restarts authentication by writing a one to the start field. It then waits for the interrupt line, reads the interrupt status register to learn whether a success or a failure/loss occurred, and so acknowledges the event. The mute request is a guarded control. It is taken only together with the encryption-status enable. While mute is asserted, the encryption-status field can no longer be changed.

Top module: `auth_ctl_regs`

## Requirements
- R1: A write to address 0x00 with bit 0 set makes `auth_active` 1 and drives `start_pulse` high for exactly the following cycle. A second such write while already active repeats the pulse (restart).
- R2: A write to address 0x00 with bit 0 clear leaves `auth_active` unchanged. Once set, `auth_active` stays set until reset. Bit 0 of reads from 0x00 and 0x01 returns `auth_active`.
- R3: `evt_pass` sets `auth_ok` in the next cycle only while `auth_active` is already 1. It is ignored otherwise. Bit 1 of a read from 0x01 returns `auth_ok`.
- R4: `evt_fail`, `evt_lost` or a restart write clears `auth_ok` in the next cycle. Clearing wins over a simultaneous `evt_pass`.
- R5: Interrupt status at 0x03 is sticky. Bit 0 records any `evt_pass`, and bit 1 records any `evt_fail` or `evt_lost`.
- R6: A read of 0x03 returns the status as it stood before the read, and then clears it. An event in the same cycle as that read remains recorded afterwards.
- R7: Address 0x02 bits [1:0] hold the interrupt mask (bit 0 for success, bit 1 for failure/loss) and read back as written. Bit 7 of a read from 0x03 is 1 exactly when a status bit with its mask bit set is pending.
- R8: `irq_n` is low exactly when some masked-in status bit is pending, and high otherwise.
- R9: Address 0x00 bit 1 is the encryption-status enable (`eess_o`) and bit 2 the mute request (`mute_o`). When not muted, a write loads bit 1, and loads bit 2 only if bit 1 of the same write is 1. While muted, bit 1 of a write is ignored and bit 2 alone is loaded. `mute_o` is never 1 while `eess_o` is 0.
- R10: `rdata` is updated in the cycle after `rd_en` and holds otherwise. Addresses 0x04 and above read 0 and ignore writes. Bits not defined above read 0.
- R11: After reset every output is 0 except `irq_n`, which is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W (8) | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid the cycle after `rd_en` |
| evt_pass | input | 1 | Engine reports authentication success |
| evt_fail | input | 1 | Engine reports authentication failure |
| evt_lost | input | 1 | Engine reports loss of authentication |
| start_pulse | output | 1 | One-cycle start/restart request to the engine |
| auth_active | output | 1 | Authentication has been enabled |
| auth_ok | output | 1 | Authentication currently succeeded |
| eess_o | output | 1 | Encryption-status enable |
| mute_o | output | 1 | Mute request |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The bench aims at same-cycle collisions. In one, a status read meets a new event; a design that clears unconditionally would lose that interrupt. In another, a restart or failure meets a success pulse; a wrong priority would leave `auth_ok` set after a restart. It also tries to set mute without the encryption-status enable, and to clear that enable while muted. A design that gets either wrong would show `mute_o` high with `eess_o` low. Zero-writes to the start field are mixed in, which catches a design that lets them drop the enable. Unmapped addresses catch an incomplete decode that aliases onto the real registers.

// File: rtl/auth_ctl_pkg.sv
package auth_ctl_pkg;
  localparam int DW         = 8;
  localparam int N_REG      = 4;
  localparam int N_SRC      = 2;
  localparam int SRC_PASS   = 0;
  localparam int SRC_FAIL   = 1;
  localparam int GLOBAL_BIT = 7;

  localparam int CTL_START  = 0;
  localparam int CTL_EESS   = 1;
  localparam int CTL_MUTE   = 2;
  localparam int CTL_W      = 3;

  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_STAT = 2'd1,
    SEL_MASK = 2'd2,
    SEL_IRQ  = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic mute;
    logic eess;
    logic active;
  } ctl_view_t;

  // Mute may only be taken together with the encryption-status enable.
  function automatic logic mute_accept(input logic wd_mute, input logic wd_eess);
    return wd_mute & wd_eess;
  endfunction

  // Any status bit that is both pending and masked in.
  function automatic logic any_pending(input logic [N_SRC-1:0] sts,
                                       input logic [N_SRC-1:0] msk);
    return |(sts & msk);
  endfunction

  function automatic logic [DW-1:0] pack_ctrl(input ctl_view_t v);
    logic [DW-1:0] r;
    r = '0;
    r[CTL_START] = v.active;
    r[CTL_EESS]  = v.eess;
    r[CTL_MUTE]  = v.mute;
    return r;
  endfunction

  function automatic logic [DW-1:0] pack_stat(input logic active, input logic ok);
    logic [DW-1:0] r;
    r = '0;
    r[0] = active;
    r[1] = ok;
    return r;
  endfunction

  function automatic logic [DW-1:0] pack_irq(input logic [N_SRC-1:0] sts, input logic glob);
    logic [DW-1:0] r;
    r = '0;
    r[N_SRC-1:0]  = sts;
    r[GLOBAL_BIT] = glob;
    return r;
  endfunction
endpackage

// File: rtl/auth_ctl_dec.sv
module auth_ctl_dec #(
  parameter int ADDR_W = 8,
  parameter int NREG   = 4
) (
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  output logic [NREG-1:0]   wr_sel,
  output logic [NREG-1:0]   rd_sel
);
  localparam int IDX_W = (NREG > 1) ? $clog2(NREG) : 1;

  logic in_range;
  assign in_range = ((addr >> IDX_W) == '0);

  for (genvar g = 0; g < NREG; g++) begin : g_sel
    logic hit;
    assign hit       = in_range && (addr[IDX_W-1:0] == IDX_W'(g));
    assign wr_sel[g] = wr_en && hit;
    assign rd_sel[g] = rd_en && hit;
  end
endmodule

// File: rtl/auth_ctl_core.sv
module auth_ctl_core
  import auth_ctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ctrl,
  input  logic [CTL_W-1:0]  ctrl_wd,
  input  logic              evt_pass,
  input  logic              evt_fail,
  input  logic              evt_lost,
  output logic              active_q,
  output logic              eess_q,
  output logic              mute_q,
  output logic              ok_q,
  output logic              start_q
);
  logic restart_req;
  logic ok_set;
  logic ok_clr;

  assign restart_req = wr_ctrl & ctrl_wd[CTL_START];
  assign ok_clr      = restart_req | evt_fail | evt_lost;
  assign ok_set      = evt_pass & active_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      start_q  <= 1'b0;
      ok_q     <= 1'b0;
    end else begin
      start_q <= restart_req;
      if (restart_req) active_q <= 1'b1;
      if (ok_clr)      ok_q <= 1'b0;
      else if (ok_set) ok_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eess_q <= 1'b0;
      mute_q <= 1'b0;
    end else if (wr_ctrl) begin
      if (mute_q) begin
        mute_q <= ctrl_wd[CTL_MUTE];
      end else begin
        eess_q <= ctrl_wd[CTL_EESS];
        mute_q <= mute_accept(ctrl_wd[CTL_MUTE], ctrl_wd[CTL_EESS]);
      end
    end
  end
endmodule

// File: rtl/auth_ctl_irq.sv
module auth_ctl_irq #(
  parameter int NSRC = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_evt,
  input  logic            wr_mask,
  input  logic [NSRC-1:0] mask_wd,
  input  logic            rd_clr,
  output logic [NSRC-1:0] sts_q,
  output logic [NSRC-1:0] mask_q,
  output logic            glob,
  output logic            irq_n
);
  for (genvar i = 0; i < NSRC; i++) begin : g_src
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sts_q[i] <= 1'b0;
      else        sts_q[i] <= src_evt[i] | (sts_q[i] & ~rd_clr);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '0;
    else if (wr_mask) mask_q <= mask_wd;
  end

  assign glob  = auth_ctl_pkg::any_pending(sts_q, mask_q);
  assign irq_n = ~glob;
endmodule

// File: rtl/auth_ctl_regs.sv
module auth_ctl_regs
  import auth_ctl_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  input  logic              evt_pass,
  input  logic              evt_fail,
  input  logic              evt_lost,
  output logic              start_pulse,
  output logic              auth_active,
  output logic              auth_ok,
  output logic              eess_o,
  output logic              mute_o,
  output logic              irq_n
);
  logic [N_REG-1:0] wr_sel;
  logic [N_REG-1:0] rd_sel;
  logic [N_SRC-1:0] src_evt;
  logic [N_SRC-1:0] sts;
  logic [N_SRC-1:0] msk;
  logic             glob;
  logic [DW-1:0]    rd_mux;
  ctl_view_t        view;

  auth_ctl_dec #(.ADDR_W(ADDR_W), .NREG(N_REG)) u_dec (
    .wr_en (wr_en),
    .rd_en (rd_en),
    .addr  (addr),
    .wr_sel(wr_sel),
    .rd_sel(rd_sel)
  );

  auth_ctl_core u_core (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_ctrl (wr_sel[SEL_CTRL]),
    .ctrl_wd (wdata[CTL_W-1:0]),
    .evt_pass(evt_pass),
    .evt_fail(evt_fail),
    .evt_lost(evt_lost),
    .active_q(auth_active),
    .eess_q  (eess_o),
    .mute_q  (mute_o),
    .ok_q    (auth_ok),
    .start_q (start_pulse)
  );

  assign src_evt[SRC_PASS] = evt_pass;
  assign src_evt[SRC_FAIL] = evt_fail | evt_lost;

  auth_ctl_irq #(.NSRC(N_SRC)) u_irq (
    .clk    (clk),
    .rst_n  (rst_n),
    .src_evt(src_evt),
    .wr_mask(wr_sel[SEL_MASK]),
    .mask_wd(wdata[N_SRC-1:0]),
    .rd_clr (rd_sel[SEL_IRQ]),
    .sts_q  (sts),
    .mask_q (msk),
    .glob   (glob),
    .irq_n  (irq_n)
  );

  assign view = '{mute: mute_o, eess: eess_o, active: auth_active};

  always_comb begin
    rd_mux = '0;
    unique case (1'b1)
      rd_sel[SEL_CTRL]: rd_mux = pack_ctrl(view);
      rd_sel[SEL_STAT]: rd_mux = pack_stat(auth_active, auth_ok);
      rd_sel[SEL_MASK]: rd_mux[N_SRC-1:0] = msk;
      rd_sel[SEL_IRQ]:  rd_mux = pack_irq(sts, glob);
      default:          rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
  end
endmodule

// File: rtl/auth_ctl_chk.sv
module auth_ctl_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [7:0]        wdata,
  input logic              evt_pass,
  input logic              evt_fail,
  input logic              evt_lost,
  input logic              start_pulse,
  input logic              auth_active,
  input logic              auth_ok,
  input logic              eess_o,
  input logic              mute_o,
  input logic              irq_n
);
  logic start_wr;
  assign start_wr = wr_en && (addr == '0) && wdata[0];

  AST_START_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |-> $past(start_wr)); // R1
  AST_ACTIVE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    auth_active |=> auth_active); // R2
  AST_OK_NEEDS_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(auth_ok) |-> $past(evt_pass && auth_active)); // R3
  AST_OK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_fail || evt_lost || start_wr) |=> !auth_ok); // R4
  AST_MUTE_NEEDS_EESS: assert property (@(posedge clk) disable iff (!rst_n)
    mute_o |-> eess_o); // R9
  AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_n) |-> $past(evt_pass || evt_fail || evt_lost || (wr_en && addr == ADDR_W'(2)))); // R8
endmodule

bind auth_ctl_regs auth_ctl_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/auth_ctl_regs_test.sv
module auth_ctl_regs_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] addr = '0, wdata = '0;
  logic       evt_pass = 1'b0, evt_fail = 1'b0, evt_lost = 1'b0;
  logic [7:0] rdata;
  logic       start_pulse, auth_active, auth_ok, eess_o, mute_o, irq_n;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // reference state
  bit m_en, m_eess, m_mute, m_ok, m_start;
  bit [1:0] m_sts, m_msk;
  bit [7:0] m_rd;
  int last_a = 0;

  always #2.5 clk = ~clk;

  auth_ctl_regs uut (.*);

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit pend();
    return (m_sts & m_msk) != 0;
  endfunction

  task automatic model(input bit w, input bit r, input int a, input bit [7:0] d,
                       input bit p, input bit f, input bit l);
    bit rs = w && a == 0 && d[0];
    bit n_eess = m_eess, n_mute = m_mute, n_ok = m_ok;
    bit [1:0] n_sts, n_msk = m_msk;
    bit [7:0] n_rd = m_rd;
    if (r) begin
      last_a = a;
      case (a)
        0: n_rd = {5'b0, m_mute, m_eess, m_en};
        1: n_rd = {6'b0, m_ok, m_en};
        2: n_rd = {6'b0, m_msk};
        3: n_rd = {pend(), 5'b0, m_sts};
        default: n_rd = 8'h00;
      endcase
    end
    if (w && a == 0) begin
      if (m_mute) n_mute = d[2];
      else begin n_eess = d[1]; n_mute = d[2] && d[1]; end
    end
    if (w && a == 2) n_msk = d[1:0];
    if (rs || f || l) n_ok = 0;
    else if (p && m_en) n_ok = 1;
    n_sts[0] = p || (m_sts[0] && !(r && a == 3));
    n_sts[1] = f || l || (m_sts[1] && !(r && a == 3));
    m_start = rs; m_en = m_en || rs; m_eess = n_eess; m_mute = n_mute;
    m_ok = n_ok; m_sts = n_sts; m_msk = n_msk; m_rd = n_rd;
  endtask

  task automatic compare();
    string rtag;
    case (last_a)
      0: rtag = "R2/R9 rdata";
      1: rtag = "R2/R3 rdata";
      2: rtag = "R7 rdata";
      3: rtag = "R5/R6/R7 rdata";
      default: rtag = "R10 rdata";
    endcase
    chk("R1 start_pulse", start_pulse, m_start);
    chk("R2 auth_active", auth_active, m_en);
    chk("R3/R4 auth_ok", auth_ok, m_ok);
    chk("R9 eess_o", eess_o, m_eess);
    chk("R9 mute_o", mute_o, m_mute);
    chk("R8 irq_n", irq_n, !pend());
    chk(rtag, rdata, m_rd);
  endtask

  task automatic step(input bit w, input bit r, input int a, input bit [7:0] d,
                      input bit p = 0, input bit f = 0, input bit l = 0);
    wr_en = w; rd_en = r; addr = 8'(a); wdata = d;
    evt_pass = p; evt_fail = f; evt_lost = l;
    @(posedge clk); #1;
    model(w, r, a, d, p, f, l);
    @(negedge clk);
    compare();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R11: reset values
    chk("R11 start_pulse", start_pulse, 0);
    chk("R11 auth_ok", auth_ok, 0);
    chk("R11 mute_o", mute_o, 0);
    chk("R11 irq_n", irq_n, 1);
    chk("R11 rdata", rdata, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R3: pass before enable is ignored for auth_ok but recorded (R5)
    step(0, 0, 0, 0, 1);
    chk("R3 ok before enable", auth_ok, 0);
    step(0, 1, 3, 0);
    chk("R5 pass recorded", rdata, 8'h01);
    // R1: start, then restart
    step(1, 0, 0, 8'h01);
    chk("R1 pulse", start_pulse, 1);
    step(0, 0, 0, 0);
    chk("R1 pulse one cycle", start_pulse, 0);
    step(1, 0, 0, 8'h00);
    chk("R2 zero write keeps active", auth_active, 1);
    step(0, 0, 0, 0, 1);
    chk("R3 ok set", auth_ok, 1);
    step(1, 0, 0, 8'h01, 1);
    chk("R4 restart beats pass", auth_ok, 0);
    step(0, 0, 0, 0, 1);
    step(0, 0, 0, 0, 1, 0, 1);
    chk("R4 loss beats pass", auth_ok, 0);
    // R7/R8 mask and interrupt
    step(1, 0, 2, 8'h03);
    chk("R8 irq low", irq_n, 0);
    step(0, 1, 3, 0, 1);
    chk("R6 read value with global", rdata, 8'h83);
    step(0, 1, 3, 0);
    chk("R6 same-cycle event kept", rdata, 8'h81);
    chk("R8 irq high after clear", irq_n, 1);
    // R9 mute rules
    step(1, 0, 0, 8'h04);
    chk("R9 mute refused", mute_o, 0);
    step(1, 0, 0, 8'h06);
    chk("R9 mute taken", mute_o, 1);
    step(1, 0, 0, 8'h04);
    chk("R9 eess held while muted", eess_o, 1);
    step(1, 0, 0, 8'h00);
    chk("R9 unmute keeps eess", eess_o, 1);
    step(1, 0, 0, 8'h00);
    chk("R9 eess cleared", eess_o, 0);
    // R10 unmapped
    step(1, 0, 8'h42, 8'hFF);
    step(0, 1, 8'h06, 0);
    chk("R10 unmapped reads zero", rdata, 0);
    step(0, 0, 0, 0);
    chk("R10 rdata holds", rdata, 0);

    for (int i = 0; i < 3000; i++) begin
      int a = $urandom_range(0, 5);
      step($urandom_range(0, 3) == 0, $urandom_range(0, 2) == 0, a, 8'($urandom),
           $urandom_range(0, 7) == 0, $urandom_range(0, 11) == 0, $urandom_range(0, 11) == 0);
    end
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL R1 watchdog: actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule